// File: doc/BRIEF.md
# Sequenced Three-Tap FIR Engine

This block computes one output of a three-tap finite impulse response filter per request, spread over several clock cycles. A controller state machine waits for a start request. It then steps through a fixed sequence of phases: capture and shift, multiply, two add phases, and completion. In each phase it drives the load enables and operand selects of a separate datapath. The datapath keeps a three-deep history of signed samples: the newest, the one before it, and the oldest. It forms the three coefficient products in parallel and adds them on one shared adder in two steps.

The user presents a sample and three coefficients and pulses `start` while the engine is idle. The sample and coefficients must stay stable until `done` rises. `done` is a one-cycle pulse. The result port holds its value until the next completion. Each request pushes exactly one new sample into the history, so successive requests filter a sample stream.

Top module: `fir3_fsmd`

## Requirements
- R1: While idle, the engine stays idle and `done` stays low until `start` is high at a clock edge; a start accepted at edge k moves the controller out of idle at that edge.
- R2: On the capture phase (the edge after acceptance), the three history registers update together: the oldest takes the previous sample, the previous takes the newest, and the newest takes `din`.
- R3: The phases run in the order capture, multiply, first add, second add, completion, idle; `done` is high in the cycle following the fourth edge after the accepting edge.
- R4: `result` equals c0·x + c1·x1 + c2·x2 in signed two's complement, exact at 2W+2 bits, where x is the newest sample, x1 the previous sample and x2 the oldest, including the most negative W-bit values.
- R5: `done` is high for exactly one cycle per accepted request.
- R6: `result` changes only when it is loaded just before `done` rises, and otherwise holds its value across idle cycles and across the following request until that request completes.
- R7: A synchronous active-high reset clears the history, products, partial sum and `result`, drives `done` low and forces idle, so the first result after reset uses zero for x1 and x2.
- R8: `start` seen while the engine is not idle is ignored: it neither shortens nor repeats the sequence nor shifts the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one filter output; sampled only when idle |
| din | input | W | New signed sample |
| coef0 | input | W | Signed coefficient for the newest sample |
| coef1 | input | W | Signed coefficient for the previous sample |
| coef2 | input | W | Signed coefficient for the oldest sample |
| result | output | 2W+2 | Signed filter output, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random signed samples and coefficients run as a stream. This tests that each history slot is paired with its own coefficient: a mispaired tap or a missed shift changes the sum. Directed requests use the most negative value in every sample and coefficient, and mix extreme values with opposite signs. These separate exact sign-extended sums from truncated or unsigned arithmetic. A request right after reset shows whether the history was cleared. A request with `start` held high through the whole sequence, followed by idle cycles, shows that busy-time starts are ignored and that `result` holds its value.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_MUL  = 3'd2,
        ST_ADD1 = 3'd3,
        ST_ADD2 = 3'd4,
        ST_DONE = 3'd5
    } fir_state_e;

    // Operand pairing for the single shared adder
    typedef enum logic {
        ADD_P0_P1  = 1'b0,
        ADD_ACC_P2 = 1'b1
    } add_sel_e;

    typedef struct packed {
        logic     hist_en;
        logic     prod_en;
        logic     acc_en;
        logic     res_en;
        add_sel_e add_sel;
    } fir_ctrl_t;

    // Control word for every state; every field has a defined value
    function automatic fir_ctrl_t ctrl_for(fir_state_e s);
        fir_ctrl_t c;
        c = '{hist_en: 1'b0, prod_en: 1'b0, acc_en: 1'b0,
              res_en: 1'b0, add_sel: ADD_P0_P1};
        case (s)
            ST_LOAD: c.hist_en = 1'b1;
            ST_MUL:  c.prod_en = 1'b1;
            ST_ADD1: begin
                c.acc_en  = 1'b1;
                c.add_sel = ADD_P0_P1;
            end
            ST_ADD2: begin
                c.res_en  = 1'b1;
                c.add_sel = ADD_ACC_P2;
            end
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
    import fir3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output fir_ctrl_t  ctrl,
    output fir_state_e state,
    output logic       done
);

    fir_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = ST_LOAD;
            ST_LOAD: st_d = ST_MUL;
            ST_MUL:  st_d = ST_ADD1;
            ST_ADD1: st_d = ST_ADD2;
            ST_ADD2: st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign ctrl  = ctrl_for(st_q);
    assign state = st_q;
    assign done  = (st_q == ST_DONE);

endmodule

// File: rtl/fir3_dp.sv
module fir3_dp
    import fir3_pkg::*;
#(
    parameter int W    = 8,
    parameter int TAPS = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  fir_ctrl_t                 ctrl,
    input  logic signed [W-1:0]       din,
    input  logic signed [W-1:0]       coef [TAPS],
    output logic signed [2*W+1:0]     result
);

    localparam int PW = 2 * W;
    localparam int SW = 2 * W + 2;

    logic signed [W-1:0]  hist [TAPS];
    logic signed [PW-1:0] prod [TAPS];
    logic signed [SW-1:0] acc_q;
    logic signed [SW-1:0] op_a, op_b, sum;

    // History: slot 0 is the newest sample
    always_ff @(posedge clk) begin
        if (rst)               hist[0] <= '0;
        else if (ctrl.hist_en) hist[0] <= din;
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst)               hist[i] <= '0;
            else if (ctrl.hist_en) hist[i] <= hist[i-1];
        end
    end

    // One multiplier per tap, all loaded in the multiply phase
    for (genvar i = 0; i < TAPS; i++) begin : g_prod
        always_ff @(posedge clk) begin
            if (rst)               prod[i] <= '0;
            else if (ctrl.prod_en) prod[i] <= coef[i] * hist[i];
        end
    end

    // Shared adder with operand multiplexers
    always_comb begin
        if (ctrl.add_sel == ADD_ACC_P2) begin
            op_a = acc_q;
            op_b = SW'(prod[2]);
        end else begin
            op_a = SW'(prod[0]);
            op_b = SW'(prod[1]);
        end
        sum = op_a + op_b;
    end

    always_ff @(posedge clk) begin
        if (rst)              acc_q <= '0;
        else if (ctrl.acc_en) acc_q <= sum;
    end

    always_ff @(posedge clk) begin
        if (rst)              result <= '0;
        else if (ctrl.res_en) result <= sum;
    end

endmodule

// File: rtl/fir3_fsmd.sv
module fir3_fsmd
    import fir3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic signed [W-1:0]   din,
    input  logic signed [W-1:0]   coef0,
    input  logic signed [W-1:0]   coef1,
    input  logic signed [W-1:0]   coef2,
    output logic signed [2*W+1:0] result,
    output logic                  done
);

    localparam int TAPS = 3;

    fir_ctrl_t           ctrl;
    fir_state_e          state;
    logic signed [W-1:0] coef [TAPS];

    assign coef[0] = coef0;
    assign coef[1] = coef1;
    assign coef[2] = coef2;

    fir3_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .state (state),
        .done  (done)
    );

    fir3_dp #(.W(W), .TAPS(TAPS)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .din    (din),
        .coef   (coef),
        .result (result)
    );

endmodule

// File: rtl/fir3_chk.sv
module fir3_chk
    import fir3_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  done,
    input logic signed [2*W+1:0] result,
    input fir_state_e            state
);

    // R1
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state == ST_LOAD));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE && !done));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (state == ST_MUL));

    // R3
    order_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADD2) |=> (state == ST_DONE && done));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ADD2) |=> $stable(result));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL && start) |=> (state == ST_ADD1));

endmodule

bind fir3_fsmd fir3_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (state)
);

// File: tb/tb_fir3_fsmd.sv
module tb_fir3_fsmd;

    localparam int W  = 8;
    localparam int RW = 2 * W + 2;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic signed [W-1:0]   din = '0, coef0 = '0, coef1 = '0, coef2 = '0;
    logic signed [RW-1:0]  result;
    logic                  done;

    int checks = 0;
    int errors = 0;
    longint h1 = 0, h2 = 0;   // reference history: previous and oldest
    logic signed [RW-1:0] last_res = '0;

    always #5 clk = ~clk;

    fir3_fsmd #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .din(din),
        .coef0(coef0), .coef1(coef1), .coef2(coef2),
        .result(result), .done(done)
    );

    function automatic longint ref_fir(longint x, longint a1, longint a2,
                                       longint k0, longint k1, longint k2);
        return k0 * x + k1 * a1 + k2 * a2;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One request; hold_start keeps start high through the busy phases
    task automatic run(input logic signed [W-1:0] x, input logic signed [W-1:0] k0,
                       input logic signed [W-1:0] k1, input logic signed [W-1:0] k2,
                       input bit hold_start, input string req);
        longint exp;
        exp = ref_fir(longint'(x), h1, h2, longint'(k0), longint'(k1), longint'(k2));
        @(negedge clk);
        din = x; coef0 = k0; coef1 = k1; coef2 = k2; start = 1'b1;
        @(posedge clk);               // accepting edge
        @(negedge clk);
        start = hold_start;
        for (int i = 1; i <= 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < 4) begin
                check("R3 done early", longint'(done), 0);
                check("R6 result held while busy", longint'(result), longint'(last_res));
            end else begin
                check("R3 done timing", longint'(done), 1);
                check({req, " result"}, longint'(result), exp);
                start = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check("R5 done one cycle", longint'(done), 0);
        check("R6 result held after done", longint'(result), exp);
        h2 = h1;
        h1 = longint'(x);
        last_res = RW'(exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic signed [W-1:0] mn;
        logic signed [W-1:0] mx;
        void'($urandom(32'd20240611));
        mn = {1'b1, {(W-1){1'b0}}};
        mx = {1'b0, {(W-1){1'b1}}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R7 reset result", longint'(result), 0);
        check("R7 reset done", longint'(done), 0);

        // R1: idle without start produces nothing
        repeat (5) begin
            @(negedge clk);
            check("R1 idle no done", longint'(done), 0);
        end

        // R4/R2: directed extremes
        run(mn, mn, mn, mn, 1'b0, "R4 first after reset (R7 zero history)");
        run(mn, mn, mn, mn, 1'b0, "R2 shift");
        run(mn, mn, mn, mn, 1'b0, "R4 all most-negative");
        run(mx, mn, mx, mn, 1'b0, "R4 mixed extremes");
        run(8'sd1, 8'sd0, 8'sd1, 8'sd0, 1'b0, "R2 tap pairing");

        // R8: start held through busy phases
        run(8'sd37, -8'sd5, 8'sd11, 8'sd3, 1'b1, "R8 busy start");
        repeat (3) begin
            @(negedge clk);
            check("R8 no relaunch", longint'(done), 0);
            check("R6 idle hold", longint'(result), longint'(last_res));
        end

        // R4: random stream
        for (int n = 0; n < 40; n++) begin
            run(W'($urandom()), W'($urandom()), W'($urandom()), W'($urandom()),
                1'b0, "R4 random");
        end

        // R7: reset mid-stream clears history
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 reset clears result", longint'(result), 0);
        h1 = 0; h2 = 0; last_res = '0;
        run(8'sd100, 8'sd3, 8'sd50, -8'sd77, 1'b0, "R7 history cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule